// File: doc/BRIEF.md
# ECC Spare-Area Stream Formatter

This block sits in the write path to a NAND array. It takes a page of data bytes, cuts it into sectors of fixed length, and passes the bytes through to the write port. After each sector it collects the error-correction words that an external parity engine computed over that sector. It packs those words into spare-area code bytes and inserts them into the outgoing byte stream. Parity computation happens outside the block; only the resulting words come in.

Three layouts are selectable per page. In the single-bit layout, each sector gives three code bytes at the end of the page. In the four-bit end layout, each sector gives ten code bytes, also at the end of the page. In the four-bit interleaved layout, each sector is followed at once by six pad bytes taken from the input, then its ten code bytes. In both end-of-page layouts the block writes a full spare area after the last sector. Any spare byte that carries no code is 0xFF.

A page begins with a start pulse that latches the page-size select and the layout. Both streams use valid/ready handshakes. Back-pressure from the write port stalls everything and loses no byte.

Top module: `ecc_spare_fmt`

## Requirements
- R1: After reset, and between pages, the block accepts no input and emits nothing. During a page, each sector's SECT_LEN data bytes pass through unchanged. Then input stalls (in_ready_o low, out_valid_o low) until the sector's ECC words arrive, one per cycle while ecc_valid_i is high: one word in layout 0, four words in layouts 1 and 2.
- R2: Layout 0 (mode_i=0): the word w is reduced to r = ~{w[27:16], w[11:0]}. Its three code bytes are r[7:0], r[15:8] and r[23:16], in that order.
- R3: Layout 0 places the three code bytes of sector s at spare offsets B+3s, B+3s+1 and B+3s+2. B is 0 for page_sel_i=0, 40 for page_sel_i=1 and 80 for page_sel_i=2.
- R4: Layouts 1 and 2 turn each word pair (p0=word 0, p1=word 1, then p0=word 2, p1=word 3) into five bytes: p0[7:0], {p0[21:16],p0[9:8]}, {p1[3:0],p0[25:22]}, {p1[17:16],p1[9:4]}, p1[25:18]. Sector code byte k (0..9) is the k-th byte of this sequence.
- R5: Layout 1 (mode_i=1) puts page code byte g = 10s+k at a spare offset that depends on the page size. For page_sel_i=0: g 0..4 go to offsets 0..4, g 5..6 to offsets 6..7, and g 7..9 to offsets 13..15, so offset 5 is never code. For page_sel_i=1 the offset is 24+g. For page_sel_i=2 it is 48+g.
- R6: Layout 2 (mode_i=2): after each sector's ECC words, six pad bytes pass from the input unchanged, then that sector's ten code bytes follow. No spare area is emitted at the end of the page.
- R7: In layouts 0 and 1 a spare area of 16, 64 or 128 bytes (page_sel_i 0, 1, 2) follows the last sector's ECC words. Every spare byte that holds no code byte is 0xFF.
- R8: While out_ready_i is low, no byte is consumed or lost, in_ready_o is low, and a pending block-generated byte holds its value.
- R9: A start with page_sel_i=3 or mode_i=3 sets err_o and emits nothing. The next valid start clears err_o.
- R10: page_sel_i 0, 1 and 2 select 1, 4 and 8 sectors per page.
- R11: start_i is ignored while a page is in progress.
- R12: ecc_valid_i outside the ECC capture phase is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a page; latches page_sel_i and mode_i |
| page_sel_i | input | 2 | 0: 1 sector, 1: 4 sectors, 2: 8 sectors, 3: invalid |
| mode_i | input | 2 | 0: single-bit, 1: four-bit end, 2: four-bit interleaved, 3: invalid |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input data or pad byte |
| in_ready_o | output | 1 | Input byte accepted when high with in_valid_i |
| ecc_valid_i | input | 1 | ECC word strobe |
| ecc_word_i | input | 32 | ECC word from the parity engine |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output byte |
| out_ready_i | input | 1 | Write port ready |
| err_o | output | 1 | Last start had an unsupported selection |

## Verification
The bench builds the block with SECT_LEN=8. A one-, four- or eight-sector page then takes only a few hundred cycles, so the bench sweeps every page size against every layout, once with the write port always ready and once under pseudo-random back-pressure. Spare-area sizes and code offsets do not depend on sector length, so the short sectors still reach every spare offset, the skipped marker byte and the 0xFF fill. Word values differ per page and per sector, so every packed bit field and every inversion is checked.

// File: rtl/ecc_spare_pkg.sv
package ecc_spare_pkg;
  localparam logic [1:0] FMT_1BIT = 2'd0;
  localparam logic [1:0] FMT_4END = 2'd1;
  localparam logic [1:0] FMT_4ILV = 2'd2;

  localparam int PAD_BYTES  = 6;
  localparam int CODE4_LEN  = 10;
  localparam int CODE1_LEN  = 3;
  localparam int MAX_SECT   = 8;
  localparam int BUF_BYTES  = MAX_SECT * CODE4_LEN;
  localparam int BUF_IDX_W  = $clog2(BUF_BYTES);

  typedef enum logic [2:0] {
    S_IDLE, S_DATA, S_ECC, S_PAD, S_CODE, S_SPARE
  } state_e;

  function automatic logic [2:0] last_sect(input logic [1:0] sel);
    case (sel)
      2'd0:    return 3'd0;
      2'd1:    return 3'd3;
      default: return 3'd7;
    endcase
  endfunction
endpackage

// File: rtl/ecc_pack.sv
module ecc_pack
  import ecc_spare_pkg::*;
(
  input  logic            one_bit_i,
  input  logic [19:0]     lo_fields_i,   // {w0[25:16], w0[9:0]} of the pair
  input  logic [31:0]     hi_word_i,
  output logic [4:0][7:0] byte_o,
  output logic [4:0]      mask_o
);
  logic [23:0] red;
  logic        unused_hi;

  assign unused_hi = ^{hi_word_i[31:28], hi_word_i[15:12]};
  assign red = ~{hi_word_i[27:16], hi_word_i[11:0]};

  always_comb begin
    if (one_bit_i) begin
      byte_o = {8'h00, 8'h00, red[23:16], red[15:8], red[7:0]};
      mask_o = 5'b00111;
    end else begin
      byte_o[0] = lo_fields_i[7:0];
      byte_o[1] = {lo_fields_i[15:10], lo_fields_i[9:8]};
      byte_o[2] = {hi_word_i[3:0], lo_fields_i[19:16]};
      byte_o[3] = {hi_word_i[17:16], hi_word_i[9:4]};
      byte_o[4] = hi_word_i[25:18];
      mask_o    = 5'b11111;
    end
  end
endmodule

// File: rtl/spare_map.sv
module spare_map
  import ecc_spare_pkg::*;
(
  input  logic [1:0] fmt_i,
  input  logic [1:0] sel_i,
  input  logic [6:0] off_i,
  output logic       hit_o,
  output logic [6:0] idx_o,
  output logic       last_o
);
  logic [6:0] size_m1, base1, len1;

  always_comb begin
    case (sel_i)
      2'd0:    begin size_m1 = 7'd15;  base1 = 7'd0;  len1 = 7'd3;  end
      2'd1:    begin size_m1 = 7'd63;  base1 = 7'd40; len1 = 7'd12; end
      default: begin size_m1 = 7'd127; base1 = 7'd80; len1 = 7'd24; end
    endcase
    last_o = (off_i == size_m1);
    hit_o  = 1'b0;
    idx_o  = '0;
    if (fmt_i == FMT_1BIT) begin
      hit_o = (off_i >= base1) && (off_i < base1 + len1);
      idx_o = off_i - base1;
    end else if (fmt_i == FMT_4END) begin
      case (sel_i)
        2'd0: begin
          if (off_i < 7'd5) begin
            hit_o = 1'b1; idx_o = off_i;
          end else if (off_i == 7'd6 || off_i == 7'd7) begin
            hit_o = 1'b1; idx_o = off_i - 7'd1;
          end else if (off_i >= 7'd13 && off_i <= 7'd15) begin
            hit_o = 1'b1; idx_o = off_i - 7'd6;
          end
        end
        2'd1: begin
          hit_o = (off_i >= 7'd24) && (off_i <= 7'd63);
          idx_o = off_i - 7'd24;
        end
        default: begin
          hit_o = (off_i >= 7'd48);
          idx_o = off_i - 7'd48;
        end
      endcase
    end
  end

  // bad-block marker byte of small pages never carries code
  always_comb begin
    if (fmt_i == FMT_4END && sel_i == 2'd0 && off_i == 7'd5)
      a_r5_marker_skipped: assert (!hit_o) else $error("code mapped onto marker byte");
  end
endmodule

// File: rtl/code_buf.sv
module code_buf
  import ecc_spare_pkg::*;
#(
  parameter int DEPTH = BUF_BYTES,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic            clk_i,
  input  logic            wr_en_i,
  input  logic [IDX_W-1:0] wr_base_i,
  input  logic [4:0][7:0] wr_byte_i,
  input  logic [4:0]      wr_mask_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [7:0]      rd_byte_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    for (int l = 0; l < 5; l++) begin
      if (wr_en_i && wr_mask_i[l])
        mem_q[wr_base_i + IDX_W'(l)] <= wr_byte_i[l];
    end
  end

  assign rd_byte_o = mem_q[rd_idx_i];

  always_comb begin
    if (wr_en_i)
      a_r4_wr_in_range: assert (int'(wr_base_i) + 4 < DEPTH) else $error("code write out of range");
  end
endmodule

// File: rtl/ecc_spare_fmt.sv
module ecc_spare_fmt
  import ecc_spare_pkg::*;
#(
  parameter int SECT_LEN = 512,
  localparam int CNT_MAX = (SECT_LEN > 128) ? SECT_LEN : 128,
  localparam int CNT_W   = $clog2(CNT_MAX)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [1:0]  page_sel_i,
  input  logic [1:0]  mode_i,
  input  logic        in_valid_i,
  input  logic [7:0]  in_data_i,
  output logic        in_ready_o,
  input  logic        ecc_valid_i,
  input  logic [31:0] ecc_word_i,
  output logic        out_valid_o,
  output logic [7:0]  out_data_o,
  input  logic        out_ready_i,
  output logic        err_o
);
  state_e            state_q;
  logic [1:0]        fmt_q, sel_q, wcnt_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [2:0]        sect_q;
  logic [19:0]       hold_q;
  logic              err_q;

  logic              one_bit, sect_last, fire, emit_buf, wr_en;
  logic [4:0][7:0]   pk_byte;
  logic [4:0]        pk_mask;
  logic              map_hit, map_last;
  logic [6:0]        map_idx, wr_base, rd_idx, sect_x10;
  logic [7:0]        rd_byte;
  logic              unused_ecc;

  assign unused_ecc = ^{ecc_word_i[31:26], ecc_word_i[15:10]};
  assign one_bit    = (fmt_q == FMT_1BIT);
  assign sect_last  = (sect_q == last_sect(sel_q));
  assign sect_x10   = {4'd0, sect_q} * 7'd10;

  ecc_pack u_pack (
    .one_bit_i  (one_bit),
    .lo_fields_i(hold_q),
    .hi_word_i  (ecc_word_i),
    .byte_o     (pk_byte),
    .mask_o     (pk_mask)
  );

  spare_map u_map (
    .fmt_i (fmt_q),
    .sel_i (sel_q),
    .off_i (cnt_q[6:0]),
    .hit_o (map_hit),
    .idx_o (map_idx),
    .last_o(map_last)
  );

  assign wr_en   = (state_q == S_ECC) && ecc_valid_i && (one_bit || wcnt_q[0]);
  assign wr_base = one_bit ? ({4'd0, sect_q} * 7'd3)
                           : (sect_x10 + (wcnt_q[1] ? 7'd5 : 7'd0));

  code_buf #(.DEPTH(BUF_BYTES)) u_buf (
    .clk_i    (clk_i),
    .wr_en_i  (wr_en),
    .wr_base_i(wr_base),
    .wr_byte_i(pk_byte),
    .wr_mask_i(pk_mask),
    .rd_idx_i (rd_idx),
    .rd_byte_o(rd_byte)
  );

  always_comb begin
    out_valid_o = 1'b0;
    out_data_o  = 8'hFF;
    in_ready_o  = 1'b0;
    rd_idx      = map_idx;
    emit_buf    = 1'b0;
    case (state_q)
      S_DATA, S_PAD: begin
        out_valid_o = in_valid_i;
        out_data_o  = in_data_i;
        in_ready_o  = out_ready_i;
      end
      S_CODE: begin
        emit_buf    = 1'b1;
        out_valid_o = 1'b1;
        rd_idx      = sect_x10 + cnt_q[6:0];
        out_data_o  = rd_byte;
      end
      S_SPARE: begin
        emit_buf    = 1'b1;
        out_valid_o = 1'b1;
        out_data_o  = map_hit ? rd_byte : 8'hFF;
      end
      default: ;
    endcase
  end

  assign fire  = out_valid_o && out_ready_i;
  assign err_o = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      fmt_q   <= '0;
      sel_q   <= '0;
      wcnt_q  <= '0;
      cnt_q   <= '0;
      sect_q  <= '0;
      hold_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          if (page_sel_i == 2'd3 || mode_i == 2'd3) begin
            err_q <= 1'b1;
          end else begin
            err_q   <= 1'b0;
            fmt_q   <= mode_i;
            sel_q   <= page_sel_i;
            cnt_q   <= '0;
            sect_q  <= '0;
            wcnt_q  <= '0;
            state_q <= S_DATA;
          end
        end
        S_DATA: if (fire) begin
          if (cnt_q == CNT_W'(SECT_LEN - 1)) begin
            cnt_q   <= '0;
            wcnt_q  <= '0;
            state_q <= S_ECC;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_ECC: if (ecc_valid_i) begin
          wcnt_q <= wcnt_q + 2'd1;
          if (!wcnt_q[0]) hold_q <= {ecc_word_i[25:16], ecc_word_i[9:0]};
          if (one_bit || wcnt_q == 2'd3) begin
            cnt_q  <= '0;
            wcnt_q <= '0;
            if (fmt_q == FMT_4ILV) begin
              state_q <= S_PAD;
            end else if (sect_last) begin
              state_q <= S_SPARE;
            end else begin
              sect_q  <= sect_q + 3'd1;
              state_q <= S_DATA;
            end
          end
        end
        S_PAD: if (fire) begin
          if (cnt_q == CNT_W'(PAD_BYTES - 1)) begin
            cnt_q   <= '0;
            state_q <= S_CODE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_CODE: if (fire) begin
          if (cnt_q == CNT_W'(CODE4_LEN - 1)) begin
            cnt_q <= '0;
            if (sect_last) begin
              state_q <= S_IDLE;
            end else begin
              sect_q  <= sect_q + 3'd1;
              state_q <= S_DATA;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_SPARE: if (fire) begin
          if (map_last) state_q <= S_IDLE;
          else          cnt_q   <= cnt_q + 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  a_r1_ecc_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ECC) |-> (!in_ready_o && !out_valid_o));
  a_r1_idle_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE) |-> (!out_valid_o && !in_ready_o));
  a_r8_ready_needs_sink: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> out_ready_i);
  a_r8_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emit_buf && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));
  a_r9_err_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!out_valid_o && !in_ready_o));
  a_r11_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_IDLE && start_i) |=> $stable(err_o));
endmodule

// File: tb/test_ecc_spare_fmt.sv
`timescale 1ns/1ps
module test_ecc_spare_fmt;
  localparam int SL = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, in_valid = 1'b0, ecc_valid = 1'b0, out_ready = 1'b1;
  logic [1:0] page_sel = '0, mode = '0;
  logic [7:0] in_data = '0;
  logic [31:0] ecc_word = '0;
  logic in_ready, out_valid, err;
  logic [7:0] out_data;

  int errors = 0, checks = 0;
  logic [7:0] obuf [256];
  logic [7:0] expb [256];
  int ocnt = 0, nexp = 0, stall_err = 0;
  bit stall_prev = 0, rand_ready = 0;
  logic [7:0] stall_data;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  ecc_spare_fmt #(.SECT_LEN(SL)) i_ecc_spare_fmt (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .page_sel_i(page_sel),
    .mode_i(mode), .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
    .ecc_valid_i(ecc_valid), .ecc_word_i(ecc_word), .out_valid_o(out_valid),
    .out_data_o(out_data), .out_ready_i(out_ready), .err_o(err));

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = rand_ready ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  always @(negedge clk) begin
    if (stall_prev && !(out_valid && out_data == stall_data)) stall_err++;
    stall_prev = out_valid && !out_ready;
    stall_data = out_data;
    if (out_valid && out_ready) begin
      if (ocnt < 256) obuf[ocnt] = out_data;
      ocnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] dbyte(int seed, int s, int i);
    return 8'((seed * 37 + s * 11 + i * 3 + 1) & 255);
  endfunction
  function automatic logic [7:0] pbyte(int seed, int s, int j);
    return 8'(8'hA0 ^ ((seed + s * 6 + j) & 255));
  endfunction
  function automatic logic [31:0] eword(int seed, int s, int k);
    return (32'(seed + 1) * 32'h9E3779B1) ^ (32'(s * 4 + k + 1) * 32'h85EBCA77) ^ 32'h0F0F1234;
  endfunction

  function automatic logic [7:0] code4(int seed, int s, int k);
    logic [31:0] p0, p1;
    int h;
    h = k / 5;
    p0 = eword(seed, s, 2 * h) & 32'h03ff03ff;
    p1 = eword(seed, s, 2 * h + 1) & 32'h03ff03ff;
    case (k % 5)
      0: return 8'(p0 & 32'hff);
      1: return 8'(((p0 >> 8) & 32'h03) | ((p0 >> 14) & 32'hfc));
      2: return 8'(((p0 >> 22) & 32'h0f) | ((p1 << 4) & 32'hf0));
      3: return 8'(((p1 >> 4) & 32'h3f) | ((p1 >> 10) & 32'hc0));
      default: return 8'((p1 >> 18) & 32'hff);
    endcase
  endfunction

  function automatic logic [7:0] code1(int seed, int s, int k);
    logic [31:0] w, e;
    w = eword(seed, s, 0);
    e = ~((w & 32'h0fff) | ((w & 32'h0fff0000) >> 4));
    return 8'((e >> (8 * k)) & 32'hff);
  endfunction

  task automatic build(input int md, input int sel, input int seed);
    int ns, sz, off, g;
    logic [7:0] sp [128];
    ns = (sel == 0) ? 1 : (sel == 1) ? 4 : 8;
    sz = (sel == 0) ? 16 : (sel == 1) ? 64 : 128;
    nexp = 0;
    for (int s = 0; s < ns; s++) begin
      for (int i = 0; i < SL; i++) begin expb[nexp] = dbyte(seed, s, i); nexp++; end
      if (md == 2) begin
        for (int j = 0; j < 6; j++) begin expb[nexp] = pbyte(seed, s, j); nexp++; end
        for (int k = 0; k < 10; k++) begin expb[nexp] = code4(seed, s, k); nexp++; end
      end
    end
    if (md != 2) begin
      for (int o = 0; o < 128; o++) sp[o] = 8'hFF;
      for (int s = 0; s < ns; s++) begin
        if (md == 0) begin
          off = ((sel == 0) ? 0 : (sel == 1) ? 40 : 80) + 3 * s;
          for (int k = 0; k < 3; k++) sp[off + k] = code1(seed, s, k);
        end else begin
          for (int k = 0; k < 10; k++) begin
            g = 10 * s + k;
            if (sel == 0) off = (g < 5) ? g : (g < 7) ? g + 1 : g + 6;
            else off = ((sel == 1) ? 24 : 48) + g;
            sp[off] = code4(seed, s, k);
          end
        end
      end
      for (int o = 0; o < sz; o++) begin expb[nexp] = sp[o]; nexp++; end
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic run_page(input int md, input int sel, input int seed, input int flag, input string tag);
    int ns, nw, mism;
    ns = (sel == 0) ? 1 : (sel == 1) ? 4 : 8;
    nw = (md == 0) ? 1 : 4;
    build(md, sel, seed);
    @(posedge clk); #1;
    ocnt = 0;
    start = 1'b1; page_sel = 2'(sel); mode = 2'(md);
    @(posedge clk); #1;
    start = 1'b0;
    if (flag == 1) begin  // R12: stray ECC strobes during data phase
      ecc_valid = 1'b1; ecc_word = 32'hDEADBEEF;
      repeat (3) @(posedge clk);
      #1 ecc_valid = 1'b0;
    end
    for (int s = 0; s < ns; s++) begin
      for (int i = 0; i < SL; i++) begin
        send_byte(dbyte(seed, s, i));
        if (flag == 2 && s == 0 && i == 0) begin
          start = 1'b1; page_sel = 2'd3;
          @(posedge clk); #1;
          start = 1'b0; page_sel = 2'(sel);
          @(negedge clk);
          chk(err == 1'b0, "R11", "start during page changed err", int'(err), 0);
          @(posedge clk); #1;
        end
      end
      if (flag == 3 && s == 0) begin
        in_valid = 1'b1; in_data = 8'h55;
        @(negedge clk);
        chk(in_ready == 1'b0, "R1", "in_ready during ECC wait", int'(in_ready), 0);
        chk(out_valid == 1'b0, "R1", "out_valid during ECC wait", int'(out_valid), 0);
        @(posedge clk); #1;
        in_valid = 1'b0;
      end
      for (int k = 0; k < nw; k++) begin
        ecc_valid = 1'b1; ecc_word = eword(seed, s, k);
        @(posedge clk); #1;
      end
      ecc_valid = 1'b0;
      if (md == 2) for (int j = 0; j < 6; j++) send_byte(pbyte(seed, s, j));
    end
    for (int t = 0; t < 3000 && ocnt < nexp; t++) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(ocnt == nexp, tag, $sformatf("byte count mode=%0d sel=%0d", md, sel), ocnt, nexp);
    mism = -1;
    for (int i = 0; i < nexp && i < ocnt; i++)
      if (mism < 0 && obuf[i] !== expb[i]) mism = i;
    if (mism >= 0)
      chk(1'b0, tag, $sformatf("byte %0d mode=%0d sel=%0d", mism, md, sel), int'(obuf[mism]), int'(expb[mism]));
    else
      chk(1'b1, tag, "content", 0, 0);
  endtask

  function automatic string tag_of(int md);
    case (md)
      0: return "R1 R2 R3 R7 R10";
      1: return "R1 R4 R5 R7 R10";
      default: return "R1 R4 R6 R10";
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b0, "R1", "outputs during reset", int'(out_valid), 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(err == 1'b0 && out_valid == 1'b0, "R1", "idle after reset", int'(err), 0);

    // R9: unsupported selections
    @(posedge clk); #1;
    start = 1'b1; page_sel = 2'd3; mode = 2'd0;
    @(posedge clk); #1;
    start = 1'b0; in_valid = 1'b1; in_data = 8'h11;
    base = ocnt;
    @(negedge clk);
    chk(err == 1'b1, "R9", "err on page_sel=3", int'(err), 1);
    repeat (10) @(negedge clk);
    chk(ocnt == base && in_ready == 1'b0, "R9", "bytes emitted after bad start", ocnt - base, 0);
    @(posedge clk); #1;
    in_valid = 1'b0;
    start = 1'b1; page_sel = 2'd0; mode = 2'd3;
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    chk(err == 1'b1, "R9", "err on mode=3", int'(err), 1);

    run_page(0, 0, 1, 0, "R1 R2 R3 R7 R10");
    chk(err == 1'b0, "R9", "err cleared by valid start", int'(err), 0);

    for (int pass = 0; pass < 2; pass++) begin
      rand_ready = (pass == 1);
      for (int md = 0; md < 3; md++)
        for (int sel = 0; sel < 3; sel++) begin
          int fl;
          fl = 0;
          if (pass == 0 && md == 0 && sel == 1) fl = 1;
          if (pass == 0 && md == 1 && sel == 2) fl = 2;
          if (pass == 0 && md == 2 && sel == 0) fl = 3;
          run_page(md, sel, 10 * pass + 3 * md + sel + 2,
                   fl, (fl == 1) ? "R12" : (pass == 1) ? "R8" : tag_of(md));
        end
    end
    rand_ready = 1'b0;
    chk(stall_err == 0, "R8", "held byte changed under back-pressure", stall_err, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule